// File: doc/BRIEF.md
# Indexed Pixel Colour Pipeline with Cursor Overlay

This block turns a stream of 8-bit colour indices, fetched from video memory by a neighbouring block, into 24-bit RGB pixels. Each incoming pixel arrives with its raster column and row and a valid strobe. The index selects an entry in a local 256-entry colour lookup table. Where the raster position falls inside a 64x64 hardware cursor, a 2-bit code from a local pattern memory can replace that colour with one of three cursor colours.

A 24-bit position word places the cursor. A 32-bit control word carries two flags: one hides the cursor, and the other forces the whole picture to black. A single write port loads the lookup table, the cursor colours and the pattern memory. Raster timing and memory fetch are handled outside the block.

Top module: `idxcur_pipe`

## Requirements
- R1: After reset, `rgb_vld_o` is 0, `rgb_o` is 0, and all three cursor colours are 0 (black) until they are written.
- R2: A pixel captured at rising edge k appears at rising edge k+1. At that edge `rgb_vld_o` copies `pix_vld_i`, and `ras_x_o`/`ras_y_o` copy the captured coordinates.
- R3: A pixel outside the cursor area takes the lookup-table entry addressed by `pix_idx_i`. The colour layout is red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: The cursor origin is `cur_pos_i[23:12]` (column xc) and `cur_pos_i[11:0]` (row yc). A pixel is inside the cursor area when xc <= x < xc+64 and yc <= y < yc+64.
- R5: Inside the area, with dx = x-xc and dy = y-yc, the pattern word is dy*8 + dx/8. The pixel's code is bits 2*(dx mod 8)+1 : 2*(dx mod 8) of that word.
- R6: Code 0 is transparent and shows the lookup-table colour. Codes 1, 2 and 3 show cursor colours 0, 1 and 2.
- R7: While `ctrl_i[23]` is 1, no pixel is treated as inside the cursor area.
- R8: While `ctrl_i[10]` is 1, every output pixel is 0, including pixels inside the cursor area. This flag wins over R3 to R7.
- R9: A write with `wr_en_i`=1 acts according to `wr_sel_i`, as follows:
  - 0 writes lookup-table entry `wr_addr_i[7:0]`.
  - 1 writes cursor colour `wr_addr_i` when that address is 0, 1 or 2; address 3 changes nothing.
  - 2 writes pattern word `wr_addr_i[8:0]` from `wr_data_i[15:0]`.
  - 3 changes nothing.
- R10: The area test does not wrap at the 12-bit coordinate limit. A cursor that extends past column or row 4095 covers only positions from its origin up to 4095, and never covers low coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_vld_i | input | 1 | Incoming pixel is valid |
| ras_x_i | input | 12 | Raster column of the incoming pixel |
| ras_y_i | input | 12 | Raster row of the incoming pixel |
| pix_idx_i | input | 8 | Colour index fetched from video memory |
| cur_pos_i | input | 24 | Cursor origin, column in 23:12, row in 11:0 |
| ctrl_i | input | 32 | Control word, bit 23 hides the cursor, bit 10 forces black |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 lookup table, 1 cursor colour, 2 pattern, 3 none |
| wr_addr_i | input | 9 | Write address |
| wr_data_i | input | 24 | Write data (RGB, or pattern word in 15:0) |
| rgb_vld_o | output | 1 | Output pixel is valid |
| rgb_o | output | 24 | Output colour |
| ras_x_o | output | 12 | Column of the output pixel |
| ras_y_o | output | 12 | Row of the output pixel |

## Verification
Every result is due at the second rising edge, counting the edge that captures the pixel. This covers the colour, the valid flag and both coordinates.

The bench drives one pixel per falling edge and holds its expected result in a two-entry queue. On each falling edge it first compares the outputs against the entry queued two falling edges earlier, and only then drives the next pixel.

Table and pattern writes happen only while the pipeline is empty. This keeps every expected value tied to the memory contents at the time the pixel was driven.

// File: rtl/idxcur_pkg.sv
package idxcur_pkg;
   typedef enum logic [1:0] {
      WSEL_CLUT    = 2'd0,
      WSEL_CURPAL  = 2'd1,
      WSEL_PATTERN = 2'd2,
      WSEL_NONE    = 2'd3
   } wsel_e;

   localparam int CTRL_W         = 32;
   localparam int CTRL_BLANK_BIT = 10;
   localparam int CTRL_NOCUR_BIT = 23;
endpackage

// File: rtl/idxcur_sram.sv
module idxcur_sram #(
   parameter int AW = 8,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd_q
);
   localparam int DEPTH = 2 ** AW;

   logic [DW-1:0] mem [DEPTH];

   // read-first: a same-edge write is seen by the next read
   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rd_q <= mem[ra];
   end
endmodule

// File: rtl/idxcur_locate.sv
module idxcur_locate #(
   parameter int COORD_W   = 12,
   parameter int DIM_LOG2  = 6,
   parameter int SLOT_LOG2 = 3
) (
   input  logic [COORD_W-1:0]              x,
   input  logic [COORD_W-1:0]              y,
   input  logic [COORD_W-1:0]              xc,
   input  logic [COORD_W-1:0]              yc,
   input  logic                            allow,
   output logic                            hit,
   output logic [2*DIM_LOG2-SLOT_LOG2-1:0] word_addr,
   output logic [SLOT_LOG2-1:0]            slot
);
   localparam logic [COORD_W-1:0] DIM = COORD_W'(2 ** DIM_LOG2);

   logic [COORD_W-1:0] dx, dy;
   logic               in_x, in_y;

   // order test first, so the offset never wraps past the coordinate limit
   always_comb begin
      dx   = x - xc;
      dy   = y - yc;
      in_x = (x >= xc) && (dx < DIM);
      in_y = (y >= yc) && (dy < DIM);
      hit  = allow && in_x && in_y;
      word_addr = {dy[DIM_LOG2-1:0], dx[DIM_LOG2-1:SLOT_LOG2]};
      slot      = dx[SLOT_LOG2-1:0];
   end
endmodule

// File: rtl/idxcur_pipe.sv
module idxcur_pipe
   import idxcur_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int CH_W     = 8,
   parameter int COORD_W  = 12,
   parameter int DIM_LOG2 = 6,
   parameter int CODE_W   = 2,
   parameter int PAT_W    = 16,
   localparam int RGB_W     = 3 * CH_W,
   localparam int SLOT_LOG2 = $clog2(PAT_W / CODE_W),
   localparam int PAT_AW    = 2 * DIM_LOG2 - SLOT_LOG2,
   localparam int WR_AW     = (IDX_W > PAT_AW) ? IDX_W : PAT_AW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pix_vld_i,
   input  logic [COORD_W-1:0]   ras_x_i,
   input  logic [COORD_W-1:0]   ras_y_i,
   input  logic [IDX_W-1:0]     pix_idx_i,
   input  logic [2*COORD_W-1:0] cur_pos_i,
   input  logic [CTRL_W-1:0]    ctrl_i,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_sel_i,
   input  logic [WR_AW-1:0]     wr_addr_i,
   input  logic [RGB_W-1:0]     wr_data_i,
   output logic                 rgb_vld_o,
   output logic [RGB_W-1:0]     rgb_o,
   output logic [COORD_W-1:0]   ras_x_o,
   output logic [COORD_W-1:0]   ras_y_o
);
   localparam int NCODE  = 2 ** CODE_W;
   localparam int CPAL_N = NCODE - 1;

   initial begin
      assert (PAT_W % CODE_W == 0) else $error("pattern word must hold whole codes");
      assert (2 ** SLOT_LOG2 == PAT_W / CODE_W) else $error("codes per word must be a power of two");
      assert (DIM_LOG2 >= SLOT_LOG2) else $error("cursor narrower than one word");
      assert (2 ** DIM_LOG2 < 2 ** COORD_W) else $error("cursor larger than raster");
      assert (CTRL_NOCUR_BIT < CTRL_W && CTRL_BLANK_BIT < CTRL_W) else $error("control bits out of range");
   end

   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl_i[CTRL_W-1:CTRL_NOCUR_BIT+1],
                          ctrl_i[CTRL_NOCUR_BIT-1:CTRL_BLANK_BIT+1],
                          ctrl_i[CTRL_BLANK_BIT-1:0]};

   // ---------------- write decode ----------------
   logic we_clut, we_pat, we_cpal;
   always_comb begin
      we_clut = wr_en_i && (wr_sel_i == WSEL_CLUT);
      we_pat  = wr_en_i && (wr_sel_i == WSEL_PATTERN);
      we_cpal = wr_en_i && (wr_sel_i == WSEL_CURPAL);
   end

   // ---------------- stage A: lookups ----------------
   logic                 loc_hit;
   logic [PAT_AW-1:0]    loc_word;
   logic [SLOT_LOG2-1:0] loc_slot;

   idxcur_locate #(
      .COORD_W(COORD_W), .DIM_LOG2(DIM_LOG2), .SLOT_LOG2(SLOT_LOG2)
   ) u_locate (
      .x(ras_x_i), .y(ras_y_i),
      .xc(cur_pos_i[2*COORD_W-1:COORD_W]), .yc(cur_pos_i[COORD_W-1:0]),
      .allow(!ctrl_i[CTRL_NOCUR_BIT]),
      .hit(loc_hit), .word_addr(loc_word), .slot(loc_slot)
   );

   logic [RGB_W-1:0] clut_q;
   logic [PAT_W-1:0] pat_q;

   idxcur_sram #(.AW(IDX_W), .DW(RGB_W)) u_clut (
      .clk(clk), .we(we_clut), .wa(wr_addr_i[IDX_W-1:0]), .wd(wr_data_i),
      .ra(pix_idx_i), .rd_q(clut_q)
   );

   idxcur_sram #(.AW(PAT_AW), .DW(PAT_W)) u_pat (
      .clk(clk), .we(we_pat), .wa(wr_addr_i[PAT_AW-1:0]), .wd(wr_data_i[PAT_W-1:0]),
      .ra(loc_word), .rd_q(pat_q)
   );

   logic                 a_vld, a_hit, a_blank;
   logic [SLOT_LOG2-1:0] a_slot;
   logic [COORD_W-1:0]   a_x, a_y;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_vld   <= 1'b0;
         a_hit   <= 1'b0;
         a_blank <= 1'b0;
         a_slot  <= '0;
         a_x     <= '0;
         a_y     <= '0;
      end else begin
         a_vld   <= pix_vld_i;
         a_hit   <= loc_hit;
         a_blank <= ctrl_i[CTRL_BLANK_BIT];
         a_slot  <= loc_slot;
         a_x     <= ras_x_i;
         a_y     <= ras_y_i;
      end
   end

   // ---------------- cursor colour registers ----------------
   logic [RGB_W-1:0] choice [NCODE];
   assign choice[0] = clut_q;

   for (genvar k = 1; k < NCODE; k++) begin : g_cpal
      logic [RGB_W-1:0] col_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            col_q <= '0;
         else if (we_cpal && wr_addr_i == WR_AW'(k - 1))
            col_q <= wr_data_i;
      end
      assign choice[k] = col_q;
   end

   // ---------------- stage B: overlay and output ----------------
   logic [CODE_W-1:0] code;
   logic [RGB_W-1:0]  colour;

   always_comb begin
      code   = pat_q[int'(a_slot) * CODE_W +: CODE_W];
      colour = a_hit ? choice[code] : clut_q;
      if (a_blank) colour = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rgb_vld_o <= 1'b0;
         rgb_o     <= '0;
         ras_x_o   <= '0;
         ras_y_o   <= '0;
      end else begin
         rgb_vld_o <= a_vld;
         rgb_o     <= colour;
         ras_x_o   <= a_x;
         ras_y_o   <= a_y;
      end
   end
endmodule

// File: rtl/idxcur_checks.sv
module idxcur_checks #(
   parameter int COORD_W = 12,
   parameter int RGB_W   = 24,
   parameter int BLANK_BIT = 10,
   parameter int CTRL_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_vld_i,
   input logic [COORD_W-1:0] ras_x_i,
   input logic [COORD_W-1:0] ras_y_i,
   input logic [CTRL_W-1:0]  ctrl_i,
   input logic               rgb_vld_o,
   input logic [RGB_W-1:0]   rgb_o,
   input logic [COORD_W-1:0] ras_x_o,
   input logic [COORD_W-1:0] ras_y_o
);
   // edges seen since reset was released, saturating at 2
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n) warm <= 2'd0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (!rgb_vld_o && rgb_o == '0));

   assert_vld_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2) |-> (rgb_vld_o == $past(pix_vld_i, 2)));

   assert_x_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2 && rgb_vld_o) |-> (ras_x_o == $past(ras_x_i, 2)));

   assert_y_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2 && rgb_vld_o) |-> (ras_y_o == $past(ras_y_i, 2)));

   assert_blank_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2 && rgb_vld_o && $past(ctrl_i[BLANK_BIT], 2)) |-> (rgb_o == '0));
endmodule

bind idxcur_pipe idxcur_checks #(
   .COORD_W(COORD_W), .RGB_W(RGB_W),
   .BLANK_BIT(idxcur_pkg::CTRL_BLANK_BIT), .CTRL_W(idxcur_pkg::CTRL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i),
   .ras_x_i(ras_x_i), .ras_y_i(ras_y_i), .ctrl_i(ctrl_i),
   .rgb_vld_o(rgb_vld_o), .rgb_o(rgb_o), .ras_x_o(ras_x_o), .ras_y_o(ras_y_o)
);

// File: tb/sim_idxcur_pipe.sv
`timescale 1ns/1ps
module sim_idxcur_pipe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_vld_i = 1'b0;
   logic [11:0] ras_x_i = '0, ras_y_i = '0;
   logic [7:0]  pix_idx_i = '0;
   logic [23:0] cur_pos_i = '0;
   logic [31:0] ctrl_i = '0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = '0;
   logic [8:0]  wr_addr_i = '0;
   logic [23:0] wr_data_i = '0;
   logic        rgb_vld_o;
   logic [23:0] rgb_o;
   logic [11:0] ras_x_o, ras_y_o;

   always #5 clk = ~clk;

   idxcur_pipe u0 (.*);

   int n_chk = 0, n_bad = 0;
   logic [23:0] m_clut [256];
   logic [23:0] m_cpal [3];
   logic [15:0] m_pat  [512];

   // pending expectations, [0] newest
   logic        q_v [2];
   logic [11:0] q_x [2], q_y [2];
   logic [23:0] q_c [2];
   string       q_t [2];

   function automatic logic [23:0] model(logic [11:0] x, logic [11:0] y, logic [7:0] idx,
                                         logic [23:0] pos, logic [31:0] ctrl);
      logic [11:0] xc, yc, dx, dy;
      logic [15:0] w;
      logic [1:0]  c;
      if (ctrl[10]) return 24'h0;                     // R8
      xc = pos[23:12]; yc = pos[11:0];
      if (!ctrl[23] && x >= xc && y >= yc && 12'(x - xc) < 12'd64 && 12'(y - yc) < 12'd64) begin
         dx = x - xc; dy = y - yc;
         w  = m_pat[int'(dy) * 8 + int'(dx) / 8];    // R5
         c  = 2'(w >> (2 * (int'(dx) % 8)));
         if (c != 2'd0) return m_cpal[int'(c) - 1];  // R6
      end
      return m_clut[idx];                              // R3
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(string tag, logic v, logic [11:0] x, logic [11:0] y, logic [7:0] idx,
                       logic [23:0] pos, logic [31:0] ctrl);
      @(negedge clk);
      if (q_v[1]) begin
         chk("R2 valid", 32'(rgb_vld_o), 32'd1);
         chk("R2 x", 32'(ras_x_o), 32'(q_x[1]));
         chk("R2 y", 32'(ras_y_o), 32'(q_y[1]));
         chk(q_t[1], 32'(rgb_o), 32'(q_c[1]));
      end else chk("R2 idle", 32'(rgb_vld_o), 32'd0);
      q_v[1] = q_v[0]; q_x[1] = q_x[0]; q_y[1] = q_y[0]; q_c[1] = q_c[0]; q_t[1] = q_t[0];
      q_v[0] = v; q_x[0] = x; q_y[0] = y; q_c[0] = model(x, y, idx, pos, ctrl); q_t[0] = tag;
      pix_vld_i = v; ras_x_i = x; ras_y_i = y; pix_idx_i = idx; cur_pos_i = pos; ctrl_i = ctrl;
   endtask

   task automatic flush();
      step("R2", 1'b0, '0, '0, '0, '0, '0);
      step("R2", 1'b0, '0, '0, '0, '0, '0);
   endtask

   // R9: model follows the write rules
   task automatic wr(logic [1:0] sel, logic [8:0] a, logic [23:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_addr_i = a; wr_data_i = d;
      case (sel)
         2'd0: m_clut[a[7:0]] = d;
         2'd1: if (a < 9'd3) m_cpal[a] = d;
         2'd2: m_pat[a] = d[15:0];
         default: ;
      endcase
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   localparam logic [23:0] POS_A = {12'd10, 12'd20};
   localparam logic [23:0] POS_E = {12'd4070, 12'd4080};

   initial begin
      for (int i = 0; i < 2; i++) begin q_v[i] = 1'b0; q_x[i] = '0; q_y[i] = '0; q_c[i] = '0; q_t[i] = ""; end
      for (int i = 0; i < 3; i++) m_cpal[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 vld", 32'(rgb_vld_o), 32'd0);
      chk("R1 rgb", 32'(rgb_o), 32'd0);

      for (int i = 0; i < 256; i++) wr(2'd0, 9'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5a});
      for (int i = 0; i < 512; i++) wr(2'd2, 9'(i), '0);
      wr(2'd2, 9'd0, 24'h0001);          // word 0, slot 0: code 1
      flush();
      step("R1 cursor colour reset", 1'b1, 12'd10, 12'd20, 8'd7, POS_A, '0);
      flush();

      wr(2'd1, 9'd0, 24'h112233);
      wr(2'd1, 9'd1, 24'h445566);
      wr(2'd1, 9'd2, 24'h778899);
      wr(2'd1, 9'd3, 24'hffffff);         // R9 ignored address
      wr(2'd3, 9'd0, 24'hababab);         // R9 ignored target
      wr(2'd2, 9'd26, 24'h00c800);        // row 3, col group 2: slot5=2, slot7=3
      wr(2'd2, 9'd511, 24'h00c000);       // row 63, col group 7: slot7=3
      flush();

      step("R3 outside", 1'b1, 12'd500, 12'd500, 8'd0, POS_A, '0);
      step("R3 outside", 1'b1, 12'd501, 12'd500, 8'd255, POS_A, '0);
      step("R3 outside", 1'b1, 12'd502, 12'd500, 8'd128, POS_A, '0);
      step("R6 code1", 1'b1, 12'd10, 12'd20, 8'd3, POS_A, '0);
      step("R5 R6 code2", 1'b1, 12'd31, 12'd23, 8'd9, POS_A, '0);
      step("R5 R6 code3", 1'b1, 12'd33, 12'd23, 8'd9, POS_A, '0);
      step("R6 transparent", 1'b1, 12'd30, 12'd23, 8'd9, POS_A, '0);
      step("R9 ignored writes", 1'b1, 12'd10, 12'd20, 8'd0, POS_A, '0);
      step("R4 left of area", 1'b1, 12'd9, 12'd20, 8'd4, POS_A, '0);
      step("R4 above area", 1'b1, 12'd10, 12'd19, 8'd4, POS_A, '0);
      step("R4 corner inside", 1'b1, 12'd73, 12'd83, 8'd4, POS_A, '0);
      step("R4 right of area", 1'b1, 12'd74, 12'd83, 8'd4, POS_A, '0);
      step("R4 below area", 1'b1, 12'd73, 12'd84, 8'd4, POS_A, '0);
      step("R7 hidden", 1'b1, 12'd31, 12'd23, 8'd9, POS_A, 32'h0080_0000);
      step("R8 blank cursor", 1'b1, 12'd31, 12'd23, 8'd9, POS_A, 32'h0000_0400);
      step("R8 blank outside", 1'b1, 12'd500, 12'd9, 8'd200, POS_A, 32'h0000_0400);
      step("R10 edge origin", 1'b1, 12'd4070, 12'd4080, 8'd11, POS_E, '0);
      step("R10 no x wrap", 1'b1, 12'd4, 12'd4080, 8'd11, POS_E, '0);
      step("R10 no y wrap", 1'b1, 12'd4070, 12'd5, 8'd11, POS_E, '0);
      step("R10 far corner", 1'b1, 12'd4095, 12'd4095, 8'd12, POS_E, '0);
      flush();

      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) wr(2'd0, 9'(i), 24'($urandom));
      for (int i = 0; i < 512; i++) wr(2'd2, 9'(i), 24'($urandom));
      for (int i = 0; i < 3; i++) wr(2'd1, 9'(i), 24'($urandom));
      flush();
      for (int i = 0; i < 4000; i++) begin
         logic [11:0] xc, yc, x, y;
         logic [31:0] c;
         xc = 12'($urandom); yc = 12'($urandom);
         x  = 12'(xc + 12'($urandom % 80) - 12'd8);
         y  = 12'(yc + 12'($urandom % 80) - 12'd8);
         c  = 32'($urandom) & 32'hff7f_fbff;
         if ($urandom % 6 == 0) c[23] = 1'b1;
         if ($urandom % 8 == 0) c[10] = 1'b1;
         step("R3 R4 R5 R6 R7 R8 R10 random", ($urandom % 5) != 0, x, y, 8'($urandom), {xc, yc}, c);
      end
      flush();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule